// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Unit

This block holds a 2048-byte space of shared counters. It serves atomic operations on 8-, 16-, 32- and 64-bit operands, one request at a time. Each request arrives as decoded fields: a load/store selector, a byte address, an operand size, a signed 22-bit increment (loads), a 64-bit data word (stores), and one flag. For loads the flag means "wait for tag" and for stores it means "overwrite instead of add". A load adds its increment to the addressed counter and returns the counter's earlier value. A store adds its data to the counter, or replaces the counter with it, and returns an empty acknowledgement.

A load with the wait flag set does not touch the counter while the `tag_pending` input is high. If that input stays high for `TIMEOUT` cycles, the load gives up. It then reports an error flag in the top bit of the operand-wide result and leaves the counter alone. Storage is kept in big-endian byte order. With `LITTLE_ENDIAN` set, the byte address is adjusted according to operand size, so software sees a little-endian layout.

Top module: `fadd_unit`

## Requirements
- R1: After reset every counter byte reads as zero.
- R2: A load (`req_is_store`=0, `req_flag`=0) returns the operand's value before the operation, zero-extended to 64 bits, and writes back that value plus the increment.
- R3: The 22-bit increment is sign-extended before the add. The add wraps modulo the operand width, and bytes outside the operand in the same 64-bit word keep their values.
- R4: `req_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. With `LITTLE_ENDIAN`=1, an operand of n bytes at address a occupies bits [8·(a mod 8)+8n−1 : 8·(a mod 8)] of the 64-bit counter at address a with its low three bits cleared. Response bits above the operand width are zero.
- R5: For a store with `req_flag`=0, the low operand-width bits of `req_data` are added to the counter. With `req_flag`=1 they replace it. Data bits above the operand width are ignored. A store response carries `rsp_data`=0 and `rsp_error`=0.
- R6: A request whose address is not a multiple of the operand size gets `rsp_error`=1 and `rsp_data`=0, and no counter changes.
- R7: A load with `req_flag`=1 makes no response while `tag_pending` is high. Once `tag_pending` is low, it completes as in R2, but bit (width−1) of the response is cleared and the low (width−1) bits carry the old value.
- R8: If `tag_pending` stays high for `TIMEOUT` cycles during a wait, the response has `rsp_error`=1 and bit (width−1) of `rsp_data` set, with all other bits zero. The counter is left unchanged.
- R9: `req_ready` drops in the cycle after a request is accepted and stays low until the response. Every accepted request yields exactly one single-cycle `rsp_valid` pulse.
- R10: Back-to-back operations on the same counter each see the result of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken at this edge |
| req_is_store | input | 1 | 1 = store, 0 = fetch-and-add load |
| req_addr | input | ADDR_W | Counter byte address |
| req_size | input | 2 | Operand size code |
| req_incr | input | INCR_W | Signed load increment |
| req_data | input | 64 | Store data |
| req_flag | input | 1 | Load: wait for tag; store: overwrite |
| tag_pending | input | 1 | External tag switch still in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 64 | Returned value / error-flagged word |
| rsp_error | output | 1 | Misaligned request or wait timeout |

## Verification
The hardest situation to reach is a tag-wait load that sits in its wait state long enough to expire. The unit must then leave the counter intact and flag the top bit at the correct operand width. The bench holds `tag_pending` high through the full timeout window on a 16-bit counter that already holds a known value. It then reads the counter back to confirm nothing changed. A second wait scenario releases the pending input part way through the window. In that case the old value is returned with its top bit masked off, the update happens only after the release, and no response appears before it.

// File: rtl/fau_pkg.sv
`timescale 1ns/1ps
// fau_pkg: shared types and size helpers for the fetch-and-add unit.
// Assumes 64-bit counter words and the size codes listed in the brief.
package fau_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } fau_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_FAIL
    } fau_state_e;

    typedef struct packed {
        logic      is_store;
        logic      flag;
        fau_size_e size;
        logic [2:0] off;
        logic [WORD_W-1:0] opnd;
    } fau_cmd_t;

    // Operand-width mask, right-aligned.
    function automatic logic [WORD_W-1:0] width_mask(fau_size_e s);
        case (s)
            SZ_8:    width_mask = 64'h0000_0000_0000_00FF;
            SZ_16:   width_mask = 64'h0000_0000_0000_FFFF;
            SZ_32:   width_mask = 64'h0000_0000_FFFF_FFFF;
            default: width_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Address bits that must be zero for an aligned operand.
    function automatic logic [2:0] align_bits(fau_size_e s);
        case (s)
            SZ_8:    align_bits = 3'd0;
            SZ_16:   align_bits = 3'd1;
            SZ_32:   align_bits = 3'd3;
            default: align_bits = 3'd7;
        endcase
    endfunction

    // Byte-address adjustment that presents big-endian storage as little-endian.
    function automatic logic [2:0] le_swizzle(fau_size_e s);
        case (s)
            SZ_8:    le_swizzle = 3'd7;
            SZ_16:   le_swizzle = 3'd6;
            SZ_32:   le_swizzle = 3'd4;
            default: le_swizzle = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/fau_regfile.sv
`timescale 1ns/1ps
// fau_regfile: counter storage of WORDS 64-bit words, cleared by reset.
// Assumes one combinational read port and one full-word write port;
// a write lands at the clock edge and is visible to the next read.
module fau_regfile #(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [63:0]      wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [63:0]      rdata
);

    logic [63:0] mem [WORDS];

    // Clear all words on reset, otherwise take the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read of the addressed word.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/fau_lane_alu.sv
`timescale 1ns/1ps
// fau_lane_alu: picks one operand lane out of a big-endian stored word,
// adds or replaces it, and merges the result back.
// Assumes off_i is the physical byte offset and is aligned to the size.
module fau_lane_alu
    import fau_pkg::*;
(
    input  logic [63:0] word_i,
    input  logic [2:0]  off_i,
    input  fau_size_e   size_i,
    input  logic [63:0] opnd_i,
    input  logic        replace_i,
    output logic [63:0] old_o,
    output logic [63:0] mask_o,
    output logic [63:0] word_o
);

    logic [3:0]  nbytes;
    logic [6:0]  lsb;
    logic [63:0] sum;
    logic [63:0] newv;

    // Locate the lane, form the new value and splice it into the word.
    always_comb begin
        nbytes = 4'd1 << size_i;
        lsb    = (7'd8 - {4'd0, off_i} - {3'd0, nbytes}) << 3;
        mask_o = width_mask(size_i);
        old_o  = (word_i >> lsb) & mask_o;
        sum    = replace_i ? opnd_i : old_o + opnd_i;
        newv   = sum & mask_o;
        word_o = (word_i & ~(mask_o << lsb)) | (newv << lsb);
    end

endmodule

// File: rtl/fadd_unit.sv
`timescale 1ns/1ps
// fadd_unit: atomic fetch-and-add / add-store / overwrite-store unit on a
// shared counter space. It takes one request at a time, optionally waits
// on tag_pending with a timeout, and runs a two-cycle read-modify-write.
// Assumes requests are held stable while req_valid is high and unaccepted.
module fadd_unit
    import fau_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int INCR_W        = 22,
    parameter int TIMEOUT       = 1024,
    parameter bit LITTLE_ENDIAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [INCR_W-1:0] req_incr,
    input  logic [63:0]       req_data,
    input  logic              req_flag,
    input  logic              tag_pending,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_error
);

    localparam int WORDS = (2 ** ADDR_W) / 8;
    localparam int IDX_W = ADDR_W - 3;
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    fau_state_e        state;
    fau_cmd_t          cmd;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  wait_cnt;
    logic [63:0]       rd_word;
    logic              rsp_valid_q;
    logic              rsp_error_q;
    logic [63:0]       rsp_data_q;

    fau_size_e         in_size;
    logic [ADDR_W-1:0] phys_addr;
    logic              misaligned;
    logic [63:0]       in_opnd;
    logic              accept;

    logic [63:0]       rf_rdata;
    logic [63:0]       old_val;
    logic [63:0]       op_mask;
    logic [63:0]       new_word;

    assign in_size = fau_size_e'(req_size);
    assign accept  = req_valid && (state == ST_IDLE);

    // Choose the byte-order view the parameter asks for.
    generate
        if (LITTLE_ENDIAN) begin : g_le
            assign phys_addr = req_addr ^ {{(ADDR_W-3){1'b0}}, le_swizzle(in_size)};
        end else begin : g_be
            assign phys_addr = req_addr;
        end
    endgenerate

    // Decode alignment and form the 64-bit operand for the request.
    always_comb begin
        misaligned = |(req_addr[2:0] & align_bits(in_size));
        if (req_is_store) begin
            in_opnd = req_data;
        end else begin
            in_opnd = {{(64-INCR_W){req_incr[INCR_W-1]}}, req_incr};
        end
    end

    fau_regfile #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) i_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (state == ST_WRITE),
        .waddr (idx),
        .wdata (new_word),
        .raddr (idx),
        .rdata (rf_rdata)
    );

    fau_lane_alu i_lane_alu (
        .word_i    (rd_word),
        .off_i     (cmd.off),
        .size_i    (cmd.size),
        .opnd_i    (cmd.opnd),
        .replace_i (cmd.is_store && cmd.flag),
        .old_o     (old_val),
        .mask_o    (op_mask),
        .word_o    (new_word)
    );

    // Sequence each request: accept, optional tag wait, read, write, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cmd         <= '0;
            idx         <= '0;
            wait_cnt    <= '0;
            rd_word     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_error_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd.is_store <= req_is_store;
                        cmd.flag     <= req_flag;
                        cmd.size     <= in_size;
                        cmd.off      <= phys_addr[2:0];
                        cmd.opnd     <= in_opnd;
                        idx          <= phys_addr[ADDR_W-1:3];
                        wait_cnt     <= '0;
                        if (misaligned) begin
                            state <= ST_FAIL;
                        end else if (!req_is_store && req_flag) begin
                            state <= ST_WAIT;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!tag_pending) begin
                        state <= ST_READ;
                    end else if (wait_cnt == CNT_W'(TIMEOUT - 1)) begin
                        rsp_valid_q <= 1'b1;
                        rsp_error_q <= 1'b1;
                        rsp_data_q  <= (width_mask(cmd.size) >> 1) + 64'd1;
                        state       <= ST_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    rd_word <= rf_rdata;
                    state   <= ST_WRITE;
                end
                ST_WRITE: begin
                    rsp_valid_q <= 1'b1;
                    rsp_error_q <= 1'b0;
                    if (cmd.is_store) begin
                        rsp_data_q <= '0;
                    end else if (cmd.flag) begin
                        rsp_data_q <= old_val & (op_mask >> 1);
                    end else begin
                        rsp_data_q <= old_val;
                    end
                    state <= ST_IDLE;
                end
                default: begin
                    rsp_valid_q <= 1'b1;
                    rsp_error_q <= 1'b1;
                    rsp_data_q  <= '0;
                    state       <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign rsp_error = rsp_error_q;

endmodule

// File: rtl/fau_checker.sv
`timescale 1ns/1ps
// fau_checker: protocol and response-format properties of fadd_unit,
// attached through bind. Tracks the outstanding request's fields itself.
module fau_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_is_store,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_flag,
    input logic              rsp_valid,
    input logic [63:0]       rsp_data,
    input logic              rsp_error
);

    logic        acc;
    logic        busy;
    logic        l_store;
    logic        l_flag;
    logic        l_mis;
    logic [1:0]  l_size;
    logic [63:0] l_mask;
    logic [63:0] l_top;

    assign acc = req_valid && req_ready;

    // Remember the fields of the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            l_store <= 1'b0;
            l_flag  <= 1'b0;
            l_mis   <= 1'b0;
            l_size  <= 2'd0;
        end else if (acc) begin
            busy    <= 1'b1;
            l_store <= req_is_store;
            l_flag  <= req_flag;
            l_size  <= req_size;
            l_mis   <= |(req_addr[2:0] & ((3'd1 << req_size) - 3'd1));
        end else if (rsp_valid) begin
            busy <= 1'b0;
        end
    end

    // Operand mask and top bit of the request in flight.
    always_comb begin
        l_mask = (l_size == 2'd3) ? '1 : ((64'd1 << (8 << l_size)) - 64'd1);
        l_top  = (l_mask >> 1) + 64'd1;
    end

    assert_single_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (!busy || rsp_valid));
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready);
    assert_rsp_has_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);
    assert_rsp_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_misaligned_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && l_mis) |-> (rsp_error && rsp_data == 64'd0));
    assert_store_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && l_store && !l_mis) |-> (!rsp_error && rsp_data == 64'd0));
    assert_rsp_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_data & ~l_mask) == 64'd0));
    assert_timeout_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error && !l_mis) |-> (!l_store && l_flag && rsp_data == l_top));
    assert_wait_top_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_error && !l_store && l_flag) |-> ((rsp_data & l_top) == 64'd0));

endmodule

bind fadd_unit fau_checker #(.ADDR_W(ADDR_W)) i_fau_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_is_store (req_is_store),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_flag     (req_flag),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_error    (rsp_error)
);

// File: tb/test_fadd_unit.sv
`timescale 1ns/1ps
// test_fadd_unit: directed scenarios, one task each, against a
// little-endian word model kept by the bench.
module test_fadd_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_store = 1'b0;
    logic [10:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [21:0] req_incr = '0;
    logic [63:0] req_data = '0;
    logic        req_flag = 1'b0;
    logic        tag_pending = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_error;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [63:0] mdl [256];

    always #2.5 clk = ~clk;

    fadd_unit i_fadd_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_addr(req_addr), .req_size(req_size),
        .req_incr(req_incr), .req_data(req_data), .req_flag(req_flag),
        .tag_pending(tag_pending), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_error(rsp_error)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] msk(input int sz);
        return (sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
    endfunction

    // Model one aligned, completed operation; returns the expected response.
    function automatic logic [63:0] mdl_op(input bit st, input int addr, input int sz,
                                           input logic [21:0] inc, input logic [63:0] dat,
                                           input bit flg);
        logic [63:0] m   = msk(sz);
        int          sh  = 8 * (addr % 8);
        logic [63:0] old = (mdl[addr/8] >> sh) & m;
        logic [63:0] op  = st ? dat : {{42{inc[21]}}, inc};
        logic [63:0] nv  = ((st && flg) ? op : old + op) & m;
        mdl[addr/8] = (mdl[addr/8] & ~(m << sh)) | (nv << sh);
        if (st) return 64'd0;
        return flg ? (old & (m >> 1)) : old;
    endfunction

    // Present a request and wait for it to be taken; R9 busy check after.
    task automatic send(input bit st, input int addr, input int sz, input logic [21:0] inc,
                        input logic [63:0] dat, input bit flg);
        @(negedge clk);
        req_valid = 1'b1; req_is_store = st; req_addr = 11'(addr); req_size = 2'(sz);
        req_incr = inc; req_data = dat; req_flag = flg;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 ready low after accept", {63'd0, req_ready}, 64'd0);
    endtask

    // Wait for the response pulse; R9 single-cycle check after it.
    task automatic recv(output logic [63:0] rd, output bit er, output int waited);
        waited = 0;
        while (!rsp_valid && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk("R9 response arrives", {63'd0, rsp_valid}, 64'd1);
        rd = rsp_data; er = rsp_error;
        @(negedge clk);
        chk("R9 response one cycle", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic op(input string tag, input bit st, input int addr, input int sz,
                      input logic [21:0] inc, input logic [63:0] dat, input bit flg);
        logic [63:0] rd; bit er; int w;
        logic [63:0] exp;
        exp = mdl_op(st, addr, sz, inc, dat, flg);
        send(st, addr, sz, inc, dat, flg);
        recv(rd, er, w);
        chk(tag, rd, exp);
        chk({tag, " error"}, {63'd0, er}, 64'd0);
    endtask

    task automatic t_reset;
        op("R1 word 0 zero", 0, 0, 3, 22'd0, 64'd0, 0);
        op("R1 word 8 zero", 0, 8, 3, 22'd0, 64'd0, 0);
        op("R1 last word zero", 0, 2040, 3, 22'd0, 64'd0, 0);
        op("R1 last byte zero", 0, 2047, 0, 22'd0, 64'd0, 0);
    endtask

    task automatic t_fetch_add;
        op("R2 first add", 0, 16, 3, 22'd5, 64'd0, 0);
        op("R2 R10 second add", 0, 16, 3, 22'd7, 64'd0, 0);
        op("R10 read back", 0, 16, 3, 22'd0, 64'd0, 0);
        chk("R2 model word", mdl[2], 64'd12);
    endtask

    task automatic t_lanes;
        op("R4 byte 3", 0, 27, 0, 22'h12, 64'd0, 0);
        op("R4 half 6", 0, 30, 1, 22'h3344, 64'd0, 0);
        op("R4 word view", 0, 24, 3, 22'd0, 64'd0, 0);
        chk("R4 lane placement", mdl[3], 64'h3344_0000_1200_0000);
        op("R4 word 4", 0, 36, 2, 22'h1ABCD, 64'd0, 0);
        op("R4 byte 7 view", 0, 39, 0, 22'd0, 64'd0, 0);
        op("R4 full word", 0, 32, 3, 22'd0, 64'd0, 0);
    endtask

    task automatic t_wrap;
        op("R3 byte minus one", 0, 40, 0, 22'h3FFFFF, 64'd0, 0);
        op("R3 byte neighbours", 0, 40, 3, 22'd0, 64'd0, 0);
        chk("R3 byte is ff", mdl[5], 64'h0000_0000_0000_00FF);
        op("R3 half minus two", 0, 50, 1, 22'h3FFFFE, 64'd0, 0);
        op("R3 half wrap", 0, 50, 1, 22'd3, 64'd0, 0);
        op("R3 half neighbours", 0, 48, 3, 22'd0, 64'd0, 0);
        chk("R3 half wrapped", mdl[6], 64'h0000_0000_0001_0000);
        op("R3 dword minus one", 0, 56, 3, 22'h3FFFFF, 64'd0, 0);
        op("R3 dword all ones", 0, 56, 3, 22'd0, 64'd0, 0);
    endtask

    task automatic t_store;
        op("R5 add store", 1, 64, 2, 22'd0, 64'd100, 0);
        op("R5 add store 2", 1, 64, 2, 22'd0, 64'd23, 0);
        op("R5 sum", 0, 64, 2, 22'd0, 64'd0, 0);
        op("R5 replace", 1, 64, 2, 22'd0, 64'd7, 1);
        op("R5 replaced", 0, 64, 2, 22'd0, 64'd0, 0);
        op("R5 wide data byte", 1, 72, 0, 22'd0, 64'hFFFF_FFFF_00AB_CDEF, 1);
        op("R5 high bits ignored", 0, 72, 3, 22'd0, 64'd0, 0);
        chk("R5 byte only", mdl[9], 64'h0000_0000_0000_00EF);
    endtask

    task automatic t_misalign;
        logic [63:0] rd; bit er; int w;
        int addrs [4] = '{81, 82, 84, 85};
        int sizes [4] = '{1, 2, 3, 3};
        for (int i = 0; i < 4; i++) begin
            send(i == 3, addrs[i], sizes[i], 22'd9, 64'd9, 0);
            recv(rd, er, w);
            chk("R6 misaligned error", {63'd0, er}, 64'd1);
            chk("R6 misaligned data", rd, 64'd0);
        end
        op("R6 word untouched", 0, 80, 3, 22'd0, 64'd0, 0);
        chk("R6 model still zero", mdl[10], 64'd0);
    endtask

    task automatic t_tagwait_ok;
        logic [63:0] rd; bit er; int w; logic [63:0] exp;
        op("R7 preset", 1, 96, 2, 22'd0, 64'h8000_0005, 1);
        tag_pending = 1'b1;
        send(0, 96, 2, 22'd1, 64'd0, 1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rsp_valid) chk("R7 no response while pending", 64'd1, 64'd0);
        end
        op_hold: begin
            n_cmp++;
        end
        tag_pending = 1'b0;
        exp = mdl_op(0, 96, 2, 22'd1, 64'd0, 1);
        recv(rd, er, w);
        chk("R7 old value top clear", rd, exp);
        chk("R7 no error", {63'd0, er}, 64'd0);
        op("R7 updated after release", 0, 96, 2, 22'd0, 64'd0, 0);
    endtask

    task automatic t_timeout;
        logic [63:0] rd; bit er; int w;
        op("R8 preset", 1, 104, 1, 22'd0, 64'h1234, 1);
        tag_pending = 1'b1;
        send(0, 104, 1, 22'd1, 64'd0, 1);
        recv(rd, er, w);
        tag_pending = 1'b0;
        chk("R8 timeout error", {63'd0, er}, 64'd1);
        chk("R8 timeout top bit", rd, 64'h8000);
        chk("R8 waited full window", {63'd0, (w >= 1000)}, 64'd1);
        op("R8 counter unchanged", 0, 104, 1, 22'd0, 64'd0, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R9 no response after reset", {63'd0, rsp_valid}, 64'd0);
        t_reset();
        t_fetch_add();
        t_lanes();
        t_wrap();
        t_store();
        t_misalign();
        t_tagwait_ok();
        t_timeout();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule